// File: doc/BRIEF.md
# Hairpin Port Aggregator Forwarder

This block sits between a group of virtual ports and the single physical uplink they share. It never switches traffic between two virtual ports. Every outbound frame from any virtual port is serialized onto the uplink by a round-robin arbiter, so traffic between two virtual ports has to leave the block and come back through the external switch.

In the inbound direction the block takes a frame header, made of a destination MAC address and a VLAN ID. It returns a delivery bitmap with one bit per virtual port. The bitmap comes from a small address table that holds the combined configuration of all virtual ports: unicast addresses, multicast groups and VLAN memberships. Each entry carries a valid flag, an address, a VLAN, a port mask and a base port. All entries are compared in parallel. A header that finds no delivery target is counted as a miss.

Frame payload is not stored here. The outbound side carries only per-port valid and end-of-frame markers, and shows which port currently owns the uplink.

Top module: `vport_hairpin_fwd`

## Requirements
- R1: A table write (`cfg_we_i`) loads every field of the entry at `cfg_idx_i`. The new contents are used by the first lookup issued after the write cycle. An entry whose valid flag is 0 never takes part in any lookup.
- R2: A header presented with `rx_hdr_valid_i` gives `rx_bmp_valid_o` one cycle later, together with the bitmap and the hit flag. For a unicast match the bitmap has exactly one bit set, at the entry's base port, and the entry's mask is ignored. An address is unicast when bit 40 of the 48-bit address is 0.
- R3: An entry matches only when both the 48-bit address and the 12-bit VLAN equal the header's.
- R4: When several entries match, the entry with the lowest index decides the result.
- R5: For a multicast match (address bit 40 set, address not all ones), the bitmap equals the entry's mask.
- R6: The all-ones address is broadcast. Its bitmap is the OR, over valid entries in the header's VLAN, of each entry's delivery set: the mask for a multicast entry, the base-port bit for a unicast entry. The hit flag is set when this OR is non-zero.
- R7: A header with no delivery target gives an all-zero bitmap with `rx_hit_o` low. It also increments `rx_miss_cnt_o`, which saturates at its maximum value and changes on no other cycle.
- R8: The uplink carries only beats of the granted port. `up_valid_o`, `up_last_o` and `up_src_o` follow that port's valid and last inputs, and no other port path exists.
- R9: Grants rotate round-robin. The search starts at the port after the one granted last, and port 0 comes first after reset.
- R10: At most one grant is active. A grant stays fixed until the granted port's last beat is accepted, and is released in the following cycle.
- R11: After reset no grant is active, no bitmap is valid and the miss counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table entry write strobe |
| cfg_idx_i | input | IDX_W | Entry index to write |
| cfg_valid_i | input | 1 | Valid flag of written entry |
| cfg_mac_i | input | 48 | Address of written entry |
| cfg_vlan_i | input | 12 | VLAN of written entry |
| cfg_mask_i | input | N_VP | Port mask of written entry |
| cfg_base_i | input | VP_W | Base port of written entry |
| rx_hdr_valid_i | input | 1 | Inbound header strobe |
| rx_dmac_i | input | 48 | Inbound destination address |
| rx_vlan_i | input | 12 | Inbound VLAN |
| rx_bmp_valid_o | output | 1 | Delivery result valid |
| rx_bmp_o | output | N_VP | Delivery bitmap |
| rx_hit_o | output | 1 | Header found a delivery target |
| rx_miss_cnt_o | output | MISS_W | Saturating miss count |
| tx_valid_i | input | N_VP | Per-port outbound beat present |
| tx_last_i | input | N_VP | Per-port end-of-frame marker |
| tx_gnt_o | output | N_VP | One-hot uplink grant |
| up_valid_o | output | 1 | Uplink beat valid |
| up_last_o | output | 1 | Uplink end-of-frame |
| up_src_o | output | VP_W | Port driving the uplink |

## Verification
On every cycle the assertions check the one-cycle result latency, the all-zero bitmap on a miss, the counter's step-or-hold behaviour with saturation, and that at most one grant is active. They also check that a grant is held until the end marker and then released, and that uplink beats come only from the granted port. Only the bench's scenarios show the data-dependent results. These are base-port versus mask selection, the need for both address and VLAN to match, lowest-index priority between duplicate entries, broadcast unions per VLAN, the effect of rewriting entries, and the rotation order of grants across ports.

// File: rtl/vpf_pkg.sv
package vpf_pkg;
  localparam int MAC_W  = 48;
  localparam int VLAN_W = 12;
  localparam int GRP_BIT = 40;
  localparam logic [MAC_W-1:0] BCAST_MAC = '1;

  function automatic logic is_group(input logic [MAC_W-1:0] mac);
    return mac[GRP_BIT];
  endfunction
endpackage

// File: rtl/vpf_addr_table.sv
module vpf_addr_table
  import vpf_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int N_VP  = 8,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int VP_W  = $clog2(N_VP)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic                         valid_i,
  input  logic [MAC_W-1:0]             mac_i,
  input  logic [VLAN_W-1:0]            vlan_i,
  input  logic [N_VP-1:0]              mask_i,
  input  logic [VP_W-1:0]              base_i,
  output logic [N_ENT-1:0]             ent_valid_o,
  output logic [N_ENT-1:0][MAC_W-1:0]  ent_mac_o,
  output logic [N_ENT-1:0][VLAN_W-1:0] ent_vlan_o,
  output logic [N_ENT-1:0][N_VP-1:0]   ent_mask_o,
  output logic [N_ENT-1:0][VP_W-1:0]   ent_base_o
);
  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic sel;
    assign sel = we_i && (idx_i == IDX_W'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_valid_o[e] <= 1'b0;
        ent_mac_o[e]   <= '0;
        ent_vlan_o[e]  <= '0;
        ent_mask_o[e]  <= '0;
        ent_base_o[e]  <= '0;
      end else if (sel) begin
        ent_valid_o[e] <= valid_i;
        ent_mac_o[e]   <= mac_i;
        ent_vlan_o[e]  <= vlan_i;
        ent_mask_o[e]  <= mask_i;
        ent_base_o[e]  <= base_i;
      end
    end
  end
endmodule

// File: rtl/vpf_lookup.sv
module vpf_lookup
  import vpf_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int N_VP   = 8,
  parameter int MISS_W = 16,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int VP_W  = $clog2(N_VP)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_ENT-1:0]             ent_valid_i,
  input  logic [N_ENT-1:0][MAC_W-1:0]  ent_mac_i,
  input  logic [N_ENT-1:0][VLAN_W-1:0] ent_vlan_i,
  input  logic [N_ENT-1:0][N_VP-1:0]   ent_mask_i,
  input  logic [N_ENT-1:0][VP_W-1:0]   ent_base_i,
  input  logic                         hdr_valid_i,
  input  logic [MAC_W-1:0]             dmac_i,
  input  logic [VLAN_W-1:0]            vlan_i,
  output logic                         bmp_valid_o,
  output logic [N_VP-1:0]              bmp_o,
  output logic                         hit_o,
  output logic [MISS_W-1:0]            miss_cnt_o
);
  logic [N_ENT-1:0]           match_vec, vlan_vec;
  logic [N_ENT-1:0][N_VP-1:0] deliver;
  logic [IDX_W-1:0]           win_idx;
  logic [N_VP-1:0]            bcast_bmp, bmp_d;
  logic                       any_match, is_bcast, hit_d;

  for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
    assign vlan_vec[e]  = ent_valid_i[e] && (ent_vlan_i[e] == vlan_i);
    assign match_vec[e] = vlan_vec[e] && (ent_mac_i[e] == dmac_i);
    assign deliver[e]   = is_group(ent_mac_i[e]) ? ent_mask_i[e]
                                                 : (N_VP'(1) << ent_base_i[e]);
  end

  // descending scan so the lowest index is written last
  always_comb begin
    win_idx = '0;
    for (int e = N_ENT - 1; e >= 0; e--)
      if (match_vec[e]) win_idx = IDX_W'(e);
  end

  always_comb begin
    bcast_bmp = '0;
    for (int e = 0; e < N_ENT; e++)
      if (vlan_vec[e]) bcast_bmp |= deliver[e];
  end

  assign any_match = |match_vec;
  assign is_bcast  = (dmac_i == BCAST_MAC);

  always_comb begin
    if (is_bcast) begin
      bmp_d = bcast_bmp;
      hit_d = |bcast_bmp;
    end else if (any_match) begin
      bmp_d = deliver[win_idx];
      hit_d = 1'b1;
    end else begin
      bmp_d = '0;
      hit_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bmp_valid_o <= 1'b0;
      bmp_o       <= '0;
      hit_o       <= 1'b0;
      miss_cnt_o  <= '0;
    end else begin
      bmp_valid_o <= hdr_valid_i;
      if (hdr_valid_i) begin
        bmp_o <= bmp_d;
        hit_o <= hit_d;
        if (!hit_d && (miss_cnt_o != '1)) miss_cnt_o <= miss_cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vpf_uplink_rr.sv
module vpf_uplink_rr #(
  parameter int N_VP = 8,
  localparam int VP_W = $clog2(N_VP)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_VP-1:0] valid_i,
  input  logic [N_VP-1:0] last_i,
  output logic [N_VP-1:0] gnt_o,
  output logic            up_valid_o,
  output logic            up_last_o,
  output logic [VP_W-1:0] up_src_o
);
  logic [N_VP-1:0] gnt_q;
  logic [VP_W-1:0] own_q, prev_q, pick;
  logic            found, busy, done;
  int              j;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    j     = 0;
    for (int k = 1; k <= N_VP; k++) begin
      j = (int'(prev_q) + k) % N_VP;
      if (!found && valid_i[j]) begin
        pick  = VP_W'(j);
        found = 1'b1;
      end
    end
  end

  assign busy       = |gnt_q;
  assign up_valid_o = busy && valid_i[own_q];
  assign up_last_o  = up_valid_o && last_i[own_q];
  assign up_src_o   = own_q;
  assign gnt_o      = gnt_q;
  assign done       = up_valid_o && up_last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= '0;
      own_q  <= '0;
      prev_q <= VP_W'(N_VP - 1);
    end else if (busy) begin
      if (done) begin
        gnt_q  <= '0;
        prev_q <= own_q;
      end
    end else if (found) begin
      gnt_q <= N_VP'(1) << pick;
      own_q <= pick;
    end
  end
endmodule

// File: rtl/vport_hairpin_fwd.sv
module vport_hairpin_fwd
  import vpf_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int N_VP   = 8,
  parameter int MISS_W = 16,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int VP_W  = $clog2(N_VP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_valid_i,
  input  logic [47:0]       cfg_mac_i,
  input  logic [11:0]       cfg_vlan_i,
  input  logic [N_VP-1:0]   cfg_mask_i,
  input  logic [VP_W-1:0]   cfg_base_i,
  input  logic              rx_hdr_valid_i,
  input  logic [47:0]       rx_dmac_i,
  input  logic [11:0]       rx_vlan_i,
  output logic              rx_bmp_valid_o,
  output logic [N_VP-1:0]   rx_bmp_o,
  output logic              rx_hit_o,
  output logic [MISS_W-1:0] rx_miss_cnt_o,
  input  logic [N_VP-1:0]   tx_valid_i,
  input  logic [N_VP-1:0]   tx_last_i,
  output logic [N_VP-1:0]   tx_gnt_o,
  output logic              up_valid_o,
  output logic              up_last_o,
  output logic [VP_W-1:0]   up_src_o
);
  logic [N_ENT-1:0]             ent_valid;
  logic [N_ENT-1:0][MAC_W-1:0]  ent_mac;
  logic [N_ENT-1:0][VLAN_W-1:0] ent_vlan;
  logic [N_ENT-1:0][N_VP-1:0]   ent_mask;
  logic [N_ENT-1:0][VP_W-1:0]   ent_base;

  vpf_addr_table #(.N_ENT(N_ENT), .N_VP(N_VP)) u_table (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .idx_i(cfg_idx_i), .valid_i(cfg_valid_i),
    .mac_i(cfg_mac_i), .vlan_i(cfg_vlan_i), .mask_i(cfg_mask_i), .base_i(cfg_base_i),
    .ent_valid_o(ent_valid), .ent_mac_o(ent_mac), .ent_vlan_o(ent_vlan),
    .ent_mask_o(ent_mask), .ent_base_o(ent_base)
  );

  vpf_lookup #(.N_ENT(N_ENT), .N_VP(N_VP), .MISS_W(MISS_W)) u_lookup (
    .clk_i, .rst_ni,
    .ent_valid_i(ent_valid), .ent_mac_i(ent_mac), .ent_vlan_i(ent_vlan),
    .ent_mask_i(ent_mask), .ent_base_i(ent_base),
    .hdr_valid_i(rx_hdr_valid_i), .dmac_i(rx_dmac_i), .vlan_i(rx_vlan_i),
    .bmp_valid_o(rx_bmp_valid_o), .bmp_o(rx_bmp_o), .hit_o(rx_hit_o),
    .miss_cnt_o(rx_miss_cnt_o)
  );

  vpf_uplink_rr #(.N_VP(N_VP)) u_rr (
    .clk_i, .rst_ni,
    .valid_i(tx_valid_i), .last_i(tx_last_i), .gnt_o(tx_gnt_o),
    .up_valid_o, .up_last_o, .up_src_o
  );
endmodule

// File: rtl/vpf_chk.sv
module vpf_chk #(
  parameter int N_VP   = 8,
  parameter int MISS_W = 16,
  localparam int VP_W  = $clog2(N_VP)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_hdr_valid_i,
  input logic              rx_bmp_valid_o,
  input logic [N_VP-1:0]   rx_bmp_o,
  input logic              rx_hit_o,
  input logic [MISS_W-1:0] rx_miss_cnt_o,
  input logic [N_VP-1:0]   tx_valid_i,
  input logic [N_VP-1:0]   tx_gnt_o,
  input logic              up_valid_o,
  input logic              up_last_o,
  input logic [VP_W-1:0]   up_src_o
);
  localparam logic [MISS_W-1:0] CNT_MAX = '1;

  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_hdr_valid_i |=> rx_bmp_valid_o);
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_hdr_valid_i |=> !rx_bmp_valid_o);
  a_r7_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_bmp_valid_o && !rx_hit_o) |-> (rx_bmp_o == '0));
  a_r7_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_bmp_valid_o && !rx_hit_o) |->
      (rx_miss_cnt_o == (($past(rx_miss_cnt_o) == CNT_MAX) ? CNT_MAX
                                                          : $past(rx_miss_cnt_o) + 1'b1)));
  a_r7_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_bmp_valid_o && !rx_hit_o) |-> $stable(rx_miss_cnt_o));
  a_r10_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tx_gnt_o));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|tx_gnt_o) && !(up_valid_o && up_last_o)) |=> $stable(tx_gnt_o));
  a_r10_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_o && up_last_o) |=> (tx_gnt_o == '0));
  a_r8_src_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_o |-> (tx_gnt_o[up_src_o] && tx_valid_i[up_src_o]));
  a_r8_last_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_last_o |-> up_valid_o);
endmodule

bind vport_hairpin_fwd vpf_chk #(.N_VP(N_VP), .MISS_W(MISS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_hdr_valid_i(rx_hdr_valid_i),
  .rx_bmp_valid_o(rx_bmp_valid_o), .rx_bmp_o(rx_bmp_o), .rx_hit_o(rx_hit_o),
  .rx_miss_cnt_o(rx_miss_cnt_o), .tx_valid_i(tx_valid_i), .tx_gnt_o(tx_gnt_o),
  .up_valid_o(up_valid_o), .up_last_o(up_last_o), .up_src_o(up_src_o)
);

// File: tb/sim_vport_hairpin_fwd.sv
module sim_vport_hairpin_fwd;
  localparam int NE = 16, NV = 8, MW = 4;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic          cfg_we = 0, cfg_valid = 0;
  logic [3:0]    cfg_idx = 0;
  logic [47:0]   cfg_mac = 0;
  logic [11:0]   cfg_vlan = 0;
  logic [7:0]    cfg_mask = 0;
  logic [2:0]    cfg_base = 0;
  logic          hdr_v = 0;
  logic [47:0]   dmac = 0;
  logic [11:0]   vlan = 0;
  logic          bmp_v, hit;
  logic [7:0]    bmp;
  logic [MW-1:0] miss;
  logic [7:0]    tx_v = 0, tx_l = 0, gnt;
  logic          up_v, up_l;
  logic [2:0]    up_s;

  vport_hairpin_fwd #(.N_ENT(NE), .N_VP(NV), .MISS_W(MW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_valid_i(cfg_valid),
    .cfg_mac_i(cfg_mac), .cfg_vlan_i(cfg_vlan), .cfg_mask_i(cfg_mask), .cfg_base_i(cfg_base),
    .rx_hdr_valid_i(hdr_v), .rx_dmac_i(dmac), .rx_vlan_i(vlan),
    .rx_bmp_valid_o(bmp_v), .rx_bmp_o(bmp), .rx_hit_o(hit), .rx_miss_cnt_o(miss),
    .tx_valid_i(tx_v), .tx_last_i(tx_l), .tx_gnt_o(gnt),
    .up_valid_o(up_v), .up_last_o(up_l), .up_src_o(up_s)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench copy of the table contents, filled from the writes it issues
  bit        m_v[NE];
  bit [47:0] m_mac[NE];
  bit [11:0] m_vlan[NE];
  bit [7:0]  m_mask[NE];
  bit [2:0]  m_base[NE];
  int        m_miss = 0;

  task automatic prog(input int i, input bit v, input bit [47:0] mac, input bit [11:0] vl,
                      input bit [7:0] mk, input bit [2:0] bs);
    @(posedge clk); #1;
    cfg_we = 1; cfg_idx = 4'(i); cfg_valid = v; cfg_mac = mac;
    cfg_vlan = vl; cfg_mask = mk; cfg_base = bs;
    @(posedge clk); #1;
    cfg_we = 0;
    m_v[i] = v; m_mac[i] = mac; m_vlan[i] = vl; m_mask[i] = mk; m_base[i] = bs;
  endtask

  function automatic bit [7:0] dset(input int i);
    return m_mac[i][40] ? m_mask[i] : (8'd1 << m_base[i]);
  endfunction

  task automatic lookup(input bit [47:0] mac, input bit [11:0] vl, input string req);
    bit [7:0] eb = 0;
    bit eh = 0;
    if (mac == '1) begin
      for (int i = 0; i < NE; i++) if (m_v[i] && m_vlan[i] == vl) eb |= dset(i);
      eh = (eb != 0);
    end else begin
      for (int i = 0; i < NE; i++)
        if (!eh && m_v[i] && m_mac[i] == mac && m_vlan[i] == vl) begin
          eb = dset(i); eh = 1;
        end
    end
    if (!eh && m_miss < 15) m_miss++;
    @(posedge clk); #1;
    hdr_v = 1; dmac = mac; vlan = vl;
    @(posedge clk); #1;
    hdr_v = 0;
    check(bmp_v == 1, {req, " valid"}, bmp_v, 1);
    check(bmp == eb && hit == eh, {req, " bitmap"}, {hit, bmp}, {eh, eb});
    check(miss == 4'(m_miss), {req, " miss count"}, miss, m_miss);
  endtask

  // outbound frame driver state
  int rem[NV], frames[NV];
  int exp_ord[$];
  int ord_i;
  bit in_frame;
  int beats;

  function automatic int flen(input int p, input int n);
    return (p % 3) + 1 + (n % 2);
  endfunction

  task automatic drive_tx();
    for (int p = 0; p < NV; p++) begin
      tx_v[p] = rem[p] > 0;
      tx_l[p] = rem[p] == 1;
    end
  endtask

  task automatic run_tx(input int cycles);
    in_frame = 0; beats = 0; ord_i = 0;
    drive_tx();
    for (int c = 0; c < cycles; c++) begin
      bit took = 0;
      int src = 0;
      @(negedge clk);
      if (up_v) begin
        took = 1; src = int'(up_s);
        check(gnt == (8'd1 << src), "R10 grant matches source", gnt, 8'd1 << src);
        check(up_l == (rem[src] == 1), "R8 last follows port", up_l, rem[src] == 1);
        if (!in_frame) begin
          int e = (ord_i < exp_ord.size()) ? exp_ord[ord_i] : -1;
          check(src == e, "R9 grant order", src, e);
          ord_i++; in_frame = 1; beats = 0;
        end
        beats++;
        if (up_l) begin
          check(beats == flen(src, frames[src]), "R10 whole frame under one grant",
                beats, flen(src, frames[src]));
          in_frame = 0;
        end
      end else if (gnt != 0) begin
        check(tx_v[up_s] == 0, "R8 idle uplink only when port idle", tx_v[up_s], 0);
      end
      @(posedge clk); #1;
      if (took) begin
        rem[src]--;
        if (rem[src] == 0 && frames[src] > 1) begin
          frames[src]--;
          rem[src] = flen(src, frames[src]);
        end else if (rem[src] == 0) frames[src] = 0;
      end
      drive_tx();
    end
    check(ord_i == exp_ord.size(), "R9 all frames sent", ord_i, exp_ord.size());
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check(bmp_v == 0 && miss == 0, "R11 lookup reset", {bmp_v, miss}, 0);
    check(gnt == 0 && up_v == 0, "R11 arbiter reset", {gnt, up_v}, 0);
    rst_n = 1;

    // R1 fill table: 0..9 unicast, 10..13 multicast, 14 duplicate of 3, 15 invalid
    for (int i = 0; i < 10; i++)
      prog(i, 1, 48'h0200_0000_1000 + 48'(i), 12'(100 + i % 3), 8'hFF, 3'((i * 3) % 8));
    for (int i = 10; i < 14; i++)
      prog(i, 1, 48'h0100_5E00_0000 + 48'(i), 12'(100 + i % 3),
           (8'h03 << (i - 10)) | 8'h80, 3'd0);
    prog(14, 1, 48'h0200_0000_1003, 12'd100, 8'h00, 3'd7);
    prog(15, 0, 48'h0200_0000_2000, 12'd100, 8'h00, 3'd5);

    // R2 unicast single bit at base, R4 entry 3 beats 14
    for (int i = 0; i < 10; i++)
      lookup(48'h0200_0000_1000 + 48'(i), 12'(100 + i % 3), "R2 R4 unicast");
    // R5 multicast mask
    for (int i = 10; i < 14; i++)
      lookup(48'h0100_5E00_0000 + 48'(i), 12'(100 + i % 3), "R5 multicast");
    // R3 vlan mismatch and address mismatch
    lookup(48'h0200_0000_1000, 12'd101, "R3 vlan mismatch");
    lookup(48'h0200_0000_1001 ^ 48'h0000_8000_0000, 12'd101, "R3 address mismatch");
    // R1 invalid entry ignored
    lookup(48'h0200_0000_2000, 12'd100, "R1 invalid entry");
    // R6 broadcast per vlan, including an empty vlan
    for (int v = 100; v < 104; v++) lookup('1, 12'(v), "R6 broadcast");
    // R1 R4 invalidate entry 3, entry 14 takes over
    prog(3, 0, 48'h0200_0000_1003, 12'd100, 8'hFF, 3'd1);
    lookup(48'h0200_0000_1003, 12'd100, "R4 duplicate after invalidate");
    prog(15, 1, 48'h0200_0000_2000, 12'd100, 8'h00, 3'd5);
    lookup(48'h0200_0000_2000, 12'd100, "R1 entry enabled");
    // R7 saturation
    for (int k = 0; k < 16; k++) lookup(48'h0200_0000_3000 + 48'(k), 12'd7, "R7 saturating miss");

    // R9 R10 all eight ports, two frames each
    exp_ord = {};
    for (int p = 0; p < NV; p++) begin frames[p] = 2; rem[p] = flen(p, 2); end
    for (int r = 0; r < 2; r++) for (int p = 0; p < NV; p++) exp_ord.push_back(p);
    run_tx(120);
    // R9 two ports only, rotation continues after port 7
    exp_ord = {2, 5, 2, 5, 2, 5};
    for (int p = 0; p < NV; p++) begin frames[p] = 0; rem[p] = 0; end
    frames[2] = 3; rem[2] = flen(2, 3);
    frames[5] = 3; rem[5] = flen(5, 3);
    run_tx(80);
    check(gnt == 0 && up_v == 0, "R10 released when idle", {gnt, up_v}, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule